// File: doc/BRIEF.md
# Endpoint Buffer Completion Controller

This block decides when a USB endpoint's packet buffer counts as finished. For an OUT endpoint, a finished buffer holds received data that the CPU can read. For an IN endpoint, a finished buffer holds data that is ready to send, and the block also detects when that data has left. It does not store data, drive the bus or run DMA. It only watches the events that those parts report: received packets with their byte counts, transmitted packets, single-byte writes into the buffer, a software request to mark the buffer valid, and a read-out acknowledge. From these events it keeps a buffer-valid flag, a one-cycle completion pulse and the buffer's base byte address.

There are two ways to run the endpoint. In single-packet mode the buffer holds one packet. In continuous mode it collects several maximum-size packets until the configured buffer size is full. A short packet or a DMA transaction count can end a continuous buffer early. Continuous mode takes effect only on bulk endpoints. On any other transfer type the block quietly behaves as single mode.

The buffer is placed by a 6-bit start block in a FIFO of 48 blocks of 64 bytes. Its size is given as a block count minus one. A configuration error output flags a buffer that would run past the last block.

Top module: `ep_buf_done_ctrl`

## Requirements
- R1: Continuous mode is in effect only when `cfg_cont_mode` is 1 and `cfg_xfer_type` equals 2'b01 (bulk). With any other type the block acts exactly as in single mode.
- R2: OUT, single mode: the first accepted received packet completes the buffer, whether it is full-size or short (zero-length included). In the next cycle `done_pulse` is 1 and `buf_valid` is 1.
- R3: OUT, continuous mode: full-size packets add up. The buffer completes on the packet that brings the byte total to (`cfg_buf_size`+1)×64.
- R4: OUT, continuous mode: a packet shorter than the max packet size completes the buffer at once. This includes a zero-length packet.
- R5: OUT, continuous mode with `dma_cnt_en`=1: the buffer completes on the packet whose running count equals `dma_txn_count`.
- R6: OUT: while `buf_valid` is 1, received packets are ignored and produce no pulse. `rd_done` clears `buf_valid` on the next edge.
- R7: IN: each `wr_strobe` counts one byte. `buf_valid` rises on the edge that counts the byte reaching the fill limit. The fill limit is the max packet size in single mode and (`cfg_buf_size`+1)×64 in continuous mode. Writes made while `buf_valid` is 1 are not counted.
- R8: IN: `sw_valid_set` while the buffer is not valid sets `buf_valid` on the next edge. It also discards the partial write count.
- R9: IN: a transmitted packet reported while `buf_valid` is 1 completes the buffer in single mode. In continuous mode, completion happens when the sent bytes reach the fill limit or the packet is short. On completion `done_pulse` is 1 and `buf_valid` is 0 in the next cycle. Transmit reports while the buffer is not valid are ignored.
- R10: `done_pulse` lasts exactly one cycle. On completion the byte and packet counters clear, so the next buffer counts from zero.
- R11: `base_addr` equals `cfg_start_block`×64 combinationally.
- R12: `cfg_err` is 1 exactly when `cfg_start_block`+`cfg_buf_size` exceeds 47.
- R13: The max packet size is encoded in `cfg_mps_sel` as 2'b00=8, 2'b01=16, 2'b10=32 and 2'b11=64 bytes. A packet of fewer bytes than this is short.
- R14: After reset `buf_valid` and `done_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_dir_in | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| cfg_xfer_type | input | 2 | Transfer type, 2'b01 = bulk |
| cfg_cont_mode | input | 1 | Request continuous mode |
| cfg_mps_sel | input | 2 | Max packet size code |
| cfg_buf_size | input | 6 | Buffer size in blocks minus one |
| cfg_start_block | input | 6 | First 64-byte block of the buffer |
| rx_pkt_valid | input | 1 | A packet was received this cycle |
| rx_pkt_bytes | input | 7 | Byte count of that packet |
| tx_pkt_valid | input | 1 | A packet was transmitted this cycle |
| tx_pkt_bytes | input | 7 | Byte count of that packet |
| wr_strobe | input | 1 | One byte written into the IN buffer |
| sw_valid_set | input | 1 | Software marks the IN buffer valid |
| rd_done | input | 1 | OUT buffer has been read out |
| dma_cnt_en | input | 1 | Enable the DMA transaction count end condition |
| dma_txn_count | input | 8 | Packets per DMA transaction |
| buf_valid | output | 1 | Buffer full (OUT) or ready to send (IN) |
| done_pulse | output | 1 | One-cycle completion strobe |
| base_addr | output | 12 | Buffer base byte address |
| cfg_err | output | 1 | Buffer runs past the last FIFO block |

## Verification
On OUT endpoints, the completion rule is driven with a single full packet, a single short packet, runs of full-size packets at two packet sizes, a run cut short by a zero-length packet, and a run ended by the DMA count. Together these show which of the three end conditions fired, and whether the counters really restart after a completion. A non-bulk endpoint with continuous mode requested is given a full packet, which separates real single-mode behaviour from a gated-off accumulation. On IN endpoints the bench fills the buffer byte by byte, forces it valid from software, and sends full, short and zero-length packets; extra writes while valid expose any miscounting of ignored bytes. A table of start-block and size pairs on both sides of block 47 checks the address and the overflow flag.

// File: rtl/ep_buf_pkg.sv
package ep_buf_pkg;
   localparam logic [1:0] XFER_BULK = 2'b01;

   function automatic int unsigned mps_of(input logic [1:0] sel, input int unsigned base);
      return base << sel;
   endfunction
endpackage

// File: rtl/ep_buf_geom.sv
module ep_buf_geom
   import ep_buf_pkg::*;
#(
   parameter int unsigned BLOCK_BYTES  = 64,
   parameter int unsigned TOTAL_BLOCKS = 48,
   parameter int unsigned NUM_W        = 6,
   parameter int unsigned SIZE_W       = 6,
   parameter int unsigned MPS_BASE     = 8,
   parameter int unsigned PKT_W        = 7,
   parameter int unsigned CNT_W        = 13,
   parameter int unsigned ADDR_W       = 12
)(
   input  logic [1:0]        xfer_type,
   input  logic              cont_req,
   input  logic [1:0]        mps_sel,
   input  logic [SIZE_W-1:0] buf_size,
   input  logic [NUM_W-1:0]  start_block,
   output logic              eff_cont,
   output logic [PKT_W-1:0]  mps,
   output logic [CNT_W-1:0]  fill_limit,
   output logic [ADDR_W-1:0] base_addr,
   output logic              cfg_err
);
   localparam int unsigned SUM_W     = (NUM_W > SIZE_W ? NUM_W : SIZE_W) + 1;
   localparam int unsigned LAST_BLK  = TOTAL_BLOCKS - 1;
   localparam int unsigned BLK_SHIFT = $clog2(BLOCK_BYTES);
   localparam bit          BLK_POW2  = (1 << BLK_SHIFT) == BLOCK_BYTES;

   logic [CNT_W-1:0] buf_bytes;
   logic [SUM_W-1:0] blk_end;

   assign eff_cont   = cont_req && (xfer_type == XFER_BULK);
   assign mps        = PKT_W'(mps_of(mps_sel, MPS_BASE));
   assign buf_bytes  = CNT_W'((CNT_W'(buf_size) + CNT_W'(1)) * CNT_W'(BLOCK_BYTES));
   assign fill_limit = eff_cont ? buf_bytes : CNT_W'(mps);
   assign blk_end    = SUM_W'(start_block) + SUM_W'(buf_size);
   assign cfg_err    = blk_end > SUM_W'(LAST_BLK);

   generate
      if (BLK_POW2) begin : g_shift_base
         assign base_addr = ADDR_W'(start_block) << BLK_SHIFT;
      end else begin : g_mul_base
         assign base_addr = ADDR_W'(ADDR_W'(start_block) * ADDR_W'(BLOCK_BYTES));
      end
   endgenerate
endmodule

// File: rtl/ep_buf_out_track.sv
module ep_buf_out_track #(
   parameter int unsigned PKT_W  = 7,
   parameter int unsigned CNT_W  = 13,
   parameter int unsigned DMAC_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              eff_cont,
   input  logic [PKT_W-1:0]  mps,
   input  logic [CNT_W-1:0]  fill_limit,
   input  logic              rx_valid,
   input  logic [PKT_W-1:0]  rx_bytes,
   input  logic              dma_en,
   input  logic [DMAC_W-1:0] dma_count,
   input  logic              rd_done,
   output logic              valid,
   output logic              done
);
   logic [CNT_W-1:0]  byte_cnt;
   logic [DMAC_W-1:0] pkt_cnt;
   logic [CNT_W-1:0]  byte_sum;
   logic [DMAC_W-1:0] pkt_next;
   logic              accept, is_short, hit_size, hit_dma, finish;

   assign accept   = en && rx_valid && !valid;
   assign byte_sum = byte_cnt + CNT_W'(rx_bytes);
   assign pkt_next = pkt_cnt + DMAC_W'(1);
   assign is_short = rx_bytes < mps;
   assign hit_size = byte_sum >= fill_limit;
   assign hit_dma  = dma_en && (pkt_next == dma_count);
   assign finish   = !eff_cont || is_short || hit_size || hit_dma;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid    <= 1'b0;
         done     <= 1'b0;
         byte_cnt <= '0;
         pkt_cnt  <= '0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            if (finish) begin
               done     <= 1'b1;
               valid    <= 1'b1;
               byte_cnt <= '0;
               pkt_cnt  <= '0;
            end else begin
               byte_cnt <= byte_sum;
               pkt_cnt  <= pkt_next;
            end
         end else if (en && rd_done && valid) begin
            valid <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/ep_buf_in_track.sv
module ep_buf_in_track #(
   parameter int unsigned PKT_W = 7,
   parameter int unsigned CNT_W = 13
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             eff_cont,
   input  logic [PKT_W-1:0] mps,
   input  logic [CNT_W-1:0] fill_limit,
   input  logic             wr_strobe,
   input  logic             sw_set,
   input  logic             tx_valid,
   input  logic [PKT_W-1:0] tx_bytes,
   output logic             valid,
   output logic             done
);
   logic [CNT_W-1:0] wr_cnt;
   logic [CNT_W-1:0] tx_cnt;
   logic [CNT_W-1:0] wr_next;
   logic [CNT_W-1:0] tx_sum;
   logic             tx_finish;

   assign wr_next   = wr_cnt + CNT_W'(1);
   assign tx_sum    = tx_cnt + CNT_W'(tx_bytes);
   assign tx_finish = !eff_cont || (tx_bytes < mps) || (tx_sum >= fill_limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid  <= 1'b0;
         done   <= 1'b0;
         wr_cnt <= '0;
         tx_cnt <= '0;
      end else begin
         done <= 1'b0;
         if (en && !valid) begin
            if (sw_set) begin
               valid  <= 1'b1;
               wr_cnt <= '0;
            end else if (wr_strobe) begin
               if (wr_next >= fill_limit) begin
                  valid  <= 1'b1;
                  wr_cnt <= '0;
               end else begin
                  wr_cnt <= wr_next;
               end
            end
         end else if (en && valid && tx_valid) begin
            if (tx_finish) begin
               done   <= 1'b1;
               valid  <= 1'b0;
               tx_cnt <= '0;
            end else begin
               tx_cnt <= tx_sum;
            end
         end
      end
   end
endmodule

// File: rtl/ep_buf_done_ctrl.sv
module ep_buf_done_ctrl #(
   parameter int unsigned BLOCK_BYTES  = 64,
   parameter int unsigned TOTAL_BLOCKS = 48,
   parameter int unsigned NUM_W        = 6,
   parameter int unsigned SIZE_W       = 6,
   parameter int unsigned MPS_BASE     = 8,
   parameter int unsigned DMAC_W       = 8,
   parameter int unsigned PKT_W        = $clog2((MPS_BASE << 3) + 1),
   parameter int unsigned ADDR_W       = $clog2(TOTAL_BLOCKS * BLOCK_BYTES)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_dir_in,
   input  logic [1:0]        cfg_xfer_type,
   input  logic              cfg_cont_mode,
   input  logic [1:0]        cfg_mps_sel,
   input  logic [SIZE_W-1:0] cfg_buf_size,
   input  logic [NUM_W-1:0]  cfg_start_block,
   input  logic              rx_pkt_valid,
   input  logic [PKT_W-1:0]  rx_pkt_bytes,
   input  logic              tx_pkt_valid,
   input  logic [PKT_W-1:0]  tx_pkt_bytes,
   input  logic              wr_strobe,
   input  logic              sw_valid_set,
   input  logic              rd_done,
   input  logic              dma_cnt_en,
   input  logic [DMAC_W-1:0] dma_txn_count,
   output logic              buf_valid,
   output logic              done_pulse,
   output logic [ADDR_W-1:0] base_addr,
   output logic              cfg_err
);
   localparam int unsigned CNT_W = $clog2(BLOCK_BYTES * (1 << SIZE_W)) + 1;

   generate
      if (TOTAL_BLOCKS > (1 << NUM_W)) begin : g_bad_blocks
         $error("TOTAL_BLOCKS does not fit the start block field");
      end
      if ((MPS_BASE << 3) > BLOCK_BYTES) begin : g_bad_mps
         $error("largest packet size exceeds one block");
      end
   endgenerate

   logic             eff_cont;
   logic [PKT_W-1:0] mps;
   logic [CNT_W-1:0] fill_limit;
   logic             out_valid, out_done, in_valid, in_done;

   ep_buf_geom #(
      .BLOCK_BYTES(BLOCK_BYTES), .TOTAL_BLOCKS(TOTAL_BLOCKS), .NUM_W(NUM_W),
      .SIZE_W(SIZE_W), .MPS_BASE(MPS_BASE), .PKT_W(PKT_W), .CNT_W(CNT_W),
      .ADDR_W(ADDR_W)
   ) u_geom (
      .xfer_type(cfg_xfer_type), .cont_req(cfg_cont_mode), .mps_sel(cfg_mps_sel),
      .buf_size(cfg_buf_size), .start_block(cfg_start_block), .eff_cont(eff_cont),
      .mps(mps), .fill_limit(fill_limit), .base_addr(base_addr), .cfg_err(cfg_err)
   );

   ep_buf_out_track #(.PKT_W(PKT_W), .CNT_W(CNT_W), .DMAC_W(DMAC_W)) u_out (
      .clk(clk), .rst_n(rst_n), .en(!cfg_dir_in), .eff_cont(eff_cont), .mps(mps),
      .fill_limit(fill_limit), .rx_valid(rx_pkt_valid), .rx_bytes(rx_pkt_bytes),
      .dma_en(dma_cnt_en), .dma_count(dma_txn_count), .rd_done(rd_done),
      .valid(out_valid), .done(out_done)
   );

   ep_buf_in_track #(.PKT_W(PKT_W), .CNT_W(CNT_W)) u_in (
      .clk(clk), .rst_n(rst_n), .en(cfg_dir_in), .eff_cont(eff_cont), .mps(mps),
      .fill_limit(fill_limit), .wr_strobe(wr_strobe), .sw_set(sw_valid_set),
      .tx_valid(tx_pkt_valid), .tx_bytes(tx_pkt_bytes),
      .valid(in_valid), .done(in_done)
   );

   assign buf_valid  = cfg_dir_in ? in_valid : out_valid;
   assign done_pulse = cfg_dir_in ? in_done  : out_done;
endmodule

// File: rtl/ep_buf_done_ctrl_chk.sv
module ep_buf_done_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_dir_in,
   input logic [1:0] cfg_xfer_type,
   input logic       rx_pkt_valid,
   input logic       sw_valid_set,
   input logic       rd_done,
   input logic       buf_valid,
   input logic       done_pulse
);
   assert_pulse_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |=> !done_pulse);

   assert_out_done_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_dir_in && done_pulse) |-> buf_valid);

   assert_in_done_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_dir_in && done_pulse) |-> !buf_valid);

   assert_nonbulk_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_dir_in && cfg_xfer_type != 2'b01 && rx_pkt_valid && !buf_valid)
      |=> (done_pulse || cfg_dir_in));

   assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_dir_in && buf_valid && !rd_done) |=> (cfg_dir_in || (buf_valid && !done_pulse)));

   assert_sw_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_dir_in && sw_valid_set && !buf_valid) |=> (buf_valid || !cfg_dir_in));
endmodule

bind ep_buf_done_ctrl ep_buf_done_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_dir_in(cfg_dir_in), .cfg_xfer_type(cfg_xfer_type),
   .rx_pkt_valid(rx_pkt_valid), .sw_valid_set(sw_valid_set), .rd_done(rd_done),
   .buf_valid(buf_valid), .done_pulse(done_pulse)
);

// File: tb/ep_buf_done_ctrl_tb.sv
module ep_buf_done_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_dir_in = 1'b0;
   logic [1:0] cfg_xfer_type = 2'b01;
   logic       cfg_cont_mode = 1'b0;
   logic [1:0] cfg_mps_sel = 2'b11;
   logic [5:0] cfg_buf_size = 6'd0;
   logic [5:0] cfg_start_block = 6'd0;
   logic       rx_pkt_valid = 1'b0;
   logic [6:0] rx_pkt_bytes = 7'd0;
   logic       tx_pkt_valid = 1'b0;
   logic [6:0] tx_pkt_bytes = 7'd0;
   logic       wr_strobe = 1'b0;
   logic       sw_valid_set = 1'b0;
   logic       rd_done = 1'b0;
   logic       dma_cnt_en = 1'b0;
   logic [7:0] dma_txn_count = 8'd0;
   logic       buf_valid, done_pulse, cfg_err;
   logic [11:0] base_addr;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   ep_buf_done_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_dir_in(cfg_dir_in), .cfg_xfer_type(cfg_xfer_type),
      .cfg_cont_mode(cfg_cont_mode), .cfg_mps_sel(cfg_mps_sel), .cfg_buf_size(cfg_buf_size),
      .cfg_start_block(cfg_start_block), .rx_pkt_valid(rx_pkt_valid),
      .rx_pkt_bytes(rx_pkt_bytes), .tx_pkt_valid(tx_pkt_valid), .tx_pkt_bytes(tx_pkt_bytes),
      .wr_strobe(wr_strobe), .sw_valid_set(sw_valid_set), .rd_done(rd_done),
      .dma_cnt_en(dma_cnt_en), .dma_txn_count(dma_txn_count), .buf_valid(buf_valid),
      .done_pulse(done_pulse), .base_addr(base_addr), .cfg_err(cfg_err)
   );

   // entry: {start block, size, expected error}
   localparam logic [12:0] GEO_TAB [10] = '{
      {6'd0, 6'd0, 1'b0},  {6'd47, 6'd0, 1'b0}, {6'd47, 6'd1, 1'b1},
      {6'd40, 6'd7, 1'b0}, {6'd40, 6'd8, 1'b1}, {6'd0, 6'd47, 1'b0},
      {6'd0, 6'd48, 1'b1}, {6'd32, 6'd15, 1'b0}, {6'd33, 6'd15, 1'b1},
      {6'd10, 6'd5, 1'b0}
   };

   task automatic check(input string tag, input int actual, input int expected);
      checks++;
      if (actual != expected) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
      end
   endtask

   task automatic chk_out(input string tag, input bit exp_done, input bit exp_valid);
      check({tag, " done"}, int'(done_pulse), int'(exp_done));
      check({tag, " valid"}, int'(buf_valid), int'(exp_valid));
   endtask

   task automatic rx(input int n);
      rx_pkt_valid = 1'b1; rx_pkt_bytes = 7'(n);
      @(negedge clk);
      rx_pkt_valid = 1'b0;
   endtask

   task automatic tx(input int n);
      tx_pkt_valid = 1'b1; tx_pkt_bytes = 7'(n);
      @(negedge clk);
      tx_pkt_valid = 1'b0;
   endtask

   task automatic wr(input int n);
      for (int i = 0; i < n; i++) begin
         wr_strobe = 1'b1;
         @(negedge clk);
      end
      wr_strobe = 1'b0;
   endtask

   task automatic read_out();
      rd_done = 1'b1;
      @(negedge clk);
      rd_done = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk_out("R14 reset", 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // geometry table (R11, R12)
      foreach (GEO_TAB[i]) begin
         cfg_start_block = GEO_TAB[i][12:7];
         cfg_buf_size    = GEO_TAB[i][6:1];
         #1;
         check("R11 base", int'(base_addr), int'(GEO_TAB[i][12:7]) * 64);
         check("R12 err", int'(cfg_err), int'(GEO_TAB[i][0]));
      end
      cfg_start_block = 6'd0; cfg_buf_size = 6'd0;
      @(negedge clk);

      // R2 OUT single
      rx(64);       chk_out("R2 full pkt", 1'b1, 1'b1);
      @(negedge clk); chk_out("R10 pulse ends", 1'b0, 1'b1);
      rx(10);       chk_out("R6 ignored while valid", 1'b0, 1'b1);
      read_out();   chk_out("R6 read clears", 1'b0, 1'b0);
      rx(5);        chk_out("R2 short pkt", 1'b1, 1'b1);
      read_out();

      // R1 non-bulk with continuous requested
      cfg_xfer_type = 2'b10; cfg_cont_mode = 1'b1; cfg_buf_size = 6'd3;
      rx(64);       chk_out("R1 nonbulk single", 1'b1, 1'b1);
      read_out();
      cfg_xfer_type = 2'b01;

      // R3 continuous, size 1 -> 128 bytes
      cfg_buf_size = 6'd1;
      rx(64);       chk_out("R3 first of two", 1'b0, 1'b0);
      rx(64);       chk_out("R3 fills", 1'b1, 1'b1);
      read_out();

      // R13 mps 8, size 0 -> 64 bytes = eight packets
      cfg_mps_sel = 2'b00; cfg_buf_size = 6'd0;
      for (int i = 0; i < 7; i++) rx(8);
      chk_out("R13 seven of eight", 1'b0, 1'b0);
      rx(8);        chk_out("R13 eighth fills", 1'b1, 1'b1);
      read_out();
      rx(7);        chk_out("R13 short below 8", 1'b1, 1'b1);
      read_out();
      cfg_mps_sel = 2'b11;

      // R4 zero-length ends continuous buffer
      cfg_buf_size = 6'd3;
      rx(64);       chk_out("R4 partial", 1'b0, 1'b0);
      rx(0);        chk_out("R4 zero-length", 1'b1, 1'b1);
      read_out();

      // R5 DMA count of 3 within a 256-byte buffer
      dma_cnt_en = 1'b1; dma_txn_count = 8'd3;
      rx(64); rx(64); chk_out("R5 two of three", 1'b0, 1'b0);
      rx(64);       chk_out("R5 count reached", 1'b1, 1'b1);
      read_out();
      dma_cnt_en = 1'b0;

      // R10 counters restart: needs four full packets now
      rx(64); rx(64); rx(64);
      chk_out("R10 counters cleared", 1'b0, 1'b0);
      rx(64);       chk_out("R10 fourth fills", 1'b1, 1'b1);
      read_out();

      // IN side, single mode, mps 16
      cfg_dir_in = 1'b1; cfg_cont_mode = 1'b0; cfg_mps_sel = 2'b01;
      @(negedge clk);
      tx(16);       chk_out("R9 tx ignored when not valid", 1'b0, 1'b0);
      wr(15);       chk_out("R7 fifteen bytes", 1'b0, 1'b0);
      wr(1);        chk_out("R7 sixteenth byte", 1'b0, 1'b1);
      wr(5);        chk_out("R7 writes while valid", 1'b0, 1'b1);
      tx(16);       chk_out("R9 single tx", 1'b1, 1'b0);
      wr(15);       chk_out("R7 ignored writes not counted", 1'b0, 1'b0);
      wr(1);        chk_out("R7 refill", 1'b0, 1'b1);
      tx(16);

      // R8 software valid, zero-length send
      wr(3);
      sw_valid_set = 1'b1; @(negedge clk); sw_valid_set = 1'b0;
      chk_out("R8 sw set", 1'b0, 1'b1);
      tx(0);        chk_out("R9 zero-length tx", 1'b1, 1'b0);
      wr(15);       chk_out("R8 partial count dropped", 1'b0, 1'b0);
      sw_valid_set = 1'b1; @(negedge clk); sw_valid_set = 1'b0;
      tx(16);

      // IN continuous, 128 bytes, mps 64
      cfg_cont_mode = 1'b1; cfg_mps_sel = 2'b11; cfg_buf_size = 6'd1;
      wr(127);      chk_out("R7 cont 127 bytes", 1'b0, 1'b0);
      wr(1);        chk_out("R7 cont full", 1'b0, 1'b1);
      tx(64);       chk_out("R9 cont partial tx", 1'b0, 1'b1);
      tx(64);       chk_out("R9 cont complete", 1'b1, 1'b0);
      sw_valid_set = 1'b1; @(negedge clk); sw_valid_set = 1'b0;
      tx(64);       chk_out("R9 cont first", 1'b0, 1'b1);
      tx(20);       chk_out("R9 cont short ends", 1'b1, 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule